// File: doc/BRIEF.md
# Two-Bank Realigning Instruction Fetch Unit

This fetch-stage unit returns a group of four consecutive instructions for any fetch address. The address does not have to sit on a line boundary. Instruction lines are stored in two banks: one holds the even-numbered lines and the other holds the odd-numbered lines. In every fetch, both banks read a whole four-instruction line. The line that contains the fetch address comes from one bank, and the line after it comes from the other bank. A rotating selector then picks four adjacent instructions out of those eight, starting at the word offset of the address.

Each slot carries a valid bit. A slot is invalid in three cases: it depends on a bank that missed, it lies after a slot flagged as a predicted-taken branch, or the fetch could not start because its own line missed. The unit also produces the next fetch address. That address is the target of the first valid taken branch, the first address past the valid slots, or the same address again when the whole fetch must be retried.

The fetch address, bank hit flags and per-slot branch hints are captured on a clock edge when fetch is enabled and no stall is present. The result is visible after that edge. A stall holds the current group. A simple write port fills the banks a line at a time.

Top module: `ifu_realign_fetch`

## Requirements
- R1: After reset, every slot valid bit is 0 and the next-address output is 0.
- R2: A request captured on an edge with fetch enabled and stall low appears at the outputs right after that edge. For a line-aligned address with both banks hitting, slots 0..3 hold words 0..3 of the addressed line, all four are valid, and the next address is the fetch address plus 16.
- R3: Instructions are 4 bytes. The line index is fetch address bits [7:4], and the word offset is bits [3:2]. Slot k holds word (offset+k) of the concatenation {addressed line, following line}. The line after line 15 is line 0.
- R4: Bit 4 of the fetch address selects the bank that holds the addressed line. A value of 0 selects the even bank, whose hit flag is the even-bank hit input. A value of 1 selects the odd bank. The other bank supplies the following line and uses the other hit flag.
- R5: If the bank of the following line misses, only slots 0 to (3 - offset) are valid.
- R6: If the bank of the addressed line misses, no slot is valid and the next address equals the fetch address.
- R7: takenHint bit k marks slot k as a predicted-taken branch, with its target on takenTgt lane k. Every slot after the first valid hinted slot is invalid, and the next address is that slot's target. A hint on a slot that is already invalid has no effect.
- R8: When no valid slot is hinted, the next address is the fetch address plus 4 times the number of valid slots.
- R9: While stall is high or fetch enable is low, the instructions, valid bits and next address all hold their values.
- R10: Valid slots always form a contiguous run that starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchEn | input | 1 | Capture a new fetch request on this edge |
| stall | input | 1 | Hold the current group (overrides fetchEn) |
| fetchPc | input | 16 | Byte fetch address |
| evenHit | input | 1 | Even-line bank hit for this request |
| oddHit | input | 1 | Odd-line bank hit for this request |
| takenHint | input | 4 | Per-slot predicted-taken flags |
| takenTgt | input | 4x16 | Per-slot branch target addresses |
| wrEn | input | 1 | Write one line into the banks |
| wrLine | input | 4 | Line index to write (bit 0 selects bank) |
| wrData | input | 4x32 | Line contents, word 0 in lane 0 |
| slotInstr | output | 4x32 | Output instruction group |
| slotValid | output | 4 | Per-slot valid flags |
| nextPc | output | 16 | Address of the next fetch |

## Verification
The bench aims at offsets 1 to 3 where the group crosses into the other bank, including the wrap from line 15 to line 0. Either a wrong bank index increment or a wrong rotation there returns words from the wrong line. It misses each bank in turn relative to address bit 4. Swapping the hit flags or ignoring a second-line miss shows up as wrong valid bits or a wrong retry address. Hints are placed on valid slots and on slots already cut off by a miss: a design that truncates on any hint, or that takes the last hint instead of the first, redirects to the wrong target. Stall and disabled cycles change every input, so a design that leaks new requests through them is caught.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int LANES = 4;
  localparam int ROT_W = $clog2(LANES);
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int BYTE_SH = 2;

  typedef struct packed {
    logic rdEn;
    logic swap;
    logic [ROT_W-1:0] rot;
  } ifuStrobe_t;
endpackage

// File: rtl/ifu_bank.sv
module ifu_bank
  import ifu_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int BANK_DEPTH = 8,
  localparam int ADDR_W = $clog2(BANK_DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [LANES-1:0][INSTR_W-1:0] wrData,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic [LANES-1:0][INSTR_W-1:0] rdLine
);
  logic [LANES-1:0][INSTR_W-1:0] store [BANK_DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdLine <= '0;
    else if (rdEn) rdLine <= store[rdIdx];
  end
endmodule

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int BANK_DEPTH = 8,
  localparam int ADDR_W = $clog2(BANK_DEPTH),
  localparam int LINE_LSB = BYTE_SH + ROT_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic fetchEn,
  input  logic stall,
  input  logic [PC_W-1:0] fetchPc,
  input  logic evenHit,
  input  logic oddHit,
  input  logic [LANES-1:0] takenHint,
  input  logic [LANES-1:0][PC_W-1:0] takenTgt,
  output ifuStrobe_t strobe,
  output logic [ADDR_W-1:0] evenIdx,
  output logic [ADDR_W-1:0] oddIdx,
  output logic [LANES-1:0] slotValid,
  output logic [PC_W-1:0] nextPc
);
  logic advance;
  logic [ADDR_W:0] lineIdx;
  logic [PC_W-1:0] pcQ;
  logic firstOddQ, firstHitQ, secondHitQ;
  logic [LANES-1:0] hintQ;
  logic [LANES-1:0][PC_W-1:0] tgtQ;
  logic [ROT_W-1:0] rot;
  logic [LANES-1:0] rawValid;
  logic takeFound;
  logic [PC_W-1:0] takeTgt;
  logic [CNT_W-1:0] validCnt;

  assign advance = fetchEn & ~stall;
  assign lineIdx = fetchPc[LINE_LSB +: ADDR_W+1];
  assign oddIdx  = lineIdx[ADDR_W:1];
  assign evenIdx = lineIdx[ADDR_W:1] + ADDR_W'(lineIdx[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      firstOddQ <= 1'b0;
      firstHitQ <= 1'b0;
      secondHitQ <= 1'b0;
      hintQ <= '0;
      tgtQ <= '0;
    end else if (advance) begin
      pcQ <= fetchPc;
      firstOddQ <= lineIdx[0];
      firstHitQ <= lineIdx[0] ? oddHit : evenHit;
      secondHitQ <= lineIdx[0] ? evenHit : oddHit;
      hintQ <= takenHint;
      tgtQ <= takenTgt;
    end
  end

  assign rot = pcQ[BYTE_SH +: ROT_W];

  always_comb begin
    logic [ROT_W:0] cand;
    for (int k = 0; k < LANES; k++) begin
      cand = {1'b0, rot} + (ROT_W+1)'(k);
      rawValid[k] = firstHitQ && (cand < (ROT_W+1)'(LANES) || secondHitQ);
    end
  end

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    takeFound = 1'b0;
    takeTgt = '0;
    validCnt = '0;
    for (int k = 0; k < LANES; k++) begin
      slotValid[k] = rawValid[k] & ~blocked;
      if (slotValid[k]) validCnt = validCnt + CNT_W'(1);
      if (slotValid[k] && hintQ[k] && !takeFound) begin
        takeFound = 1'b1;
        takeTgt = tgtQ[k];
      end
      blocked = blocked | (slotValid[k] & hintQ[k]);
    end
  end

  assign nextPc = takeFound ? takeTgt
                : pcQ + {{(PC_W-CNT_W-BYTE_SH){1'b0}}, validCnt, {BYTE_SH{1'b0}}};

  assign strobe.rdEn = advance;
  assign strobe.swap = firstOddQ;
  assign strobe.rot  = rot;

  // R6
  first_miss_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(advance && rstN) &&
     !($past(fetchPc[LINE_LSB]) ? $past(oddHit) : $past(evenHit)))
    |-> (slotValid == '0 && nextPc == $past(fetchPc)));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(advance)) |-> ($stable(slotValid) && $stable(nextPc)));

  // R5
  second_miss_trim_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(advance && rstN) &&
     !($past(fetchPc[LINE_LSB]) ? $past(evenHit) : $past(oddHit)))
    |-> ($countones(slotValid) <= LANES - int'($past(fetchPc[BYTE_SH +: ROT_W]))));

  // R10
  valid_prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((slotValid & (slotValid + LANES'(1))) == '0));

  // R7
  single_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(slotValid & hintQ) <= 1));
endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int BANK_DEPTH = 8,
  localparam int ADDR_W = $clog2(BANK_DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  ifuStrobe_t strobe,
  input  logic [ADDR_W-1:0] evenIdx,
  input  logic [ADDR_W-1:0] oddIdx,
  input  logic wrEn,
  input  logic [ADDR_W:0] wrLine,
  input  logic [LANES-1:0][INSTR_W-1:0] wrData,
  output logic [LANES-1:0][INSTR_W-1:0] slotInstr
);
  logic [1:0][LANES-1:0][INSTR_W-1:0] bankLine;
  logic [LANES-1:0][INSTR_W-1:0] firstLine, secondLine;
  logic [2*LANES-1:0][INSTR_W-1:0] cand;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ifu_bank #(.INSTR_W(INSTR_W), .BANK_DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk),
      .rstN(rstN),
      .wrEn(wrEn && (wrLine[0] == 1'(b))),
      .wrIdx(wrLine[ADDR_W:1]),
      .wrData(wrData),
      .rdEn(strobe.rdEn),
      .rdIdx((b == 0) ? evenIdx : oddIdx),
      .rdLine(bankLine[b])
    );
  end

  assign firstLine  = strobe.swap ? bankLine[1] : bankLine[0];
  assign secondLine = strobe.swap ? bankLine[0] : bankLine[1];
  assign cand = {secondLine, firstLine};

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    logic [ROT_W:0] sel;
    assign sel = {1'b0, strobe.rot} + (ROT_W+1)'(k);
    assign slotInstr[k] = cand[sel];
  end

  // R9
  instr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.rdEn) && !$past(wrEn)) |-> $stable(slotInstr));
endmodule

// File: rtl/ifu_realign_fetch.sv
module ifu_realign_fetch
  import ifu_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int INSTR_W = 32,
  parameter int BANK_DEPTH = 8,
  localparam int ADDR_W = $clog2(BANK_DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic fetchEn,
  input  logic stall,
  input  logic [PC_W-1:0] fetchPc,
  input  logic evenHit,
  input  logic oddHit,
  input  logic [LANES-1:0] takenHint,
  input  logic [LANES-1:0][PC_W-1:0] takenTgt,
  input  logic wrEn,
  input  logic [ADDR_W:0] wrLine,
  input  logic [LANES-1:0][INSTR_W-1:0] wrData,
  output logic [LANES-1:0][INSTR_W-1:0] slotInstr,
  output logic [LANES-1:0] slotValid,
  output logic [PC_W-1:0] nextPc
);
  ifuStrobe_t strobe;
  logic [ADDR_W-1:0] evenIdx, oddIdx;

  ifu_ctrl #(.PC_W(PC_W), .BANK_DEPTH(BANK_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .stall(stall),
    .fetchPc(fetchPc), .evenHit(evenHit), .oddHit(oddHit),
    .takenHint(takenHint), .takenTgt(takenTgt),
    .strobe(strobe), .evenIdx(evenIdx), .oddIdx(oddIdx),
    .slotValid(slotValid), .nextPc(nextPc)
  );

  ifu_datapath #(.INSTR_W(INSTR_W), .BANK_DEPTH(BANK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evenIdx(evenIdx), .oddIdx(oddIdx),
    .wrEn(wrEn), .wrLine(wrLine), .wrData(wrData),
    .slotInstr(slotInstr)
  );
endmodule

// File: tb/sim_ifu_realign_fetch.sv
`timescale 1ns/1ps
module sim_ifu_realign_fetch;
  localparam int PC_W = 16;
  localparam int INSTR_W = 32;
  localparam int NLINES = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchEn = 1'b0, stall = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic evenHit = 1'b0, oddHit = 1'b0;
  logic [3:0] takenHint = '0;
  logic [3:0][PC_W-1:0] takenTgt = '0;
  logic wrEn = 1'b0;
  logic [3:0] wrLine = '0;
  logic [3:0][INSTR_W-1:0] wrData = '0;
  logic [3:0][INSTR_W-1:0] slotInstr;
  logic [3:0] slotValid;
  logic [PC_W-1:0] nextPc;

  ifu_realign_fetch u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [INSTR_W-1:0] mem [NLINES][4];

  // request last accepted by the block (reset state = empty request)
  logic [PC_W-1:0] rPc = '0;
  logic rEh = 1'b0, rOh = 1'b0;
  logic [3:0] rHint = '0;
  logic [3:0][PC_W-1:0] rTgt = '0;

  logic [3:0] expValid;
  logic [3:0][INSTR_W-1:0] expInstr;
  logic [PC_W-1:0] expNext;

  task automatic model();
    int li, sl, off, cnt;
    logic fh, sh, blk, found;
    li = int'(rPc[7:4]);
    sl = (li + 1) % NLINES;
    off = int'(rPc[3:2]);
    fh = rPc[4] ? rOh : rEh;
    sh = rPc[4] ? rEh : rOh;
    blk = 1'b0; found = 1'b0; cnt = 0;
    expNext = rPc;
    for (int k = 0; k < 4; k++) begin
      int c = off + k;
      expInstr[k] = (c < 4) ? mem[li][c] : mem[sl][c-4];
      expValid[k] = fh && (c < 4 || sh) && !blk;
      if (expValid[k]) cnt++;
      if (expValid[k] && rHint[k] && !found) begin
        found = 1'b1;
        expNext = rTgt[k];
      end
      if (expValid[k] && rHint[k]) blk = 1'b1;
    end
    if (!found) expNext = rPc + PC_W'(cnt * 4);
  endtask

  task automatic check(string tag);
    model();
    checks++;
    if (slotValid !== expValid) begin
      fails++;
      $display("FAIL %s valid pc=%h actual=%b expected=%b", tag, rPc, slotValid, expValid);
    end
    checks++;
    if (nextPc !== expNext) begin
      fails++;
      $display("FAIL %s nextPc pc=%h actual=%h expected=%h", tag, rPc, nextPc, expNext);
    end
    for (int k = 0; k < 4; k++) begin
      if (expValid[k]) begin
        checks++;
        if (slotInstr[k] !== expInstr[k]) begin
          fails++;
          $display("FAIL %s slot%0d pc=%h actual=%h expected=%h", tag, k, rPc,
                   slotInstr[k], expInstr[k]);
        end
      end
    end
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc, input logic eh, input logic oh,
                       input logic [3:0] hint, input logic [3:0][PC_W-1:0] tgt,
                       input logic en, input logic st, input string tag);
    fetchPc = pc; evenHit = eh; oddHit = oh; takenHint = hint; takenTgt = tgt;
    fetchEn = en; stall = st;
    if (en && !st) begin
      rPc = pc; rEh = eh; rOh = oh; rHint = hint; rTgt = tgt;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [3:0][PC_W-1:0] rndTgt();
    logic [3:0][PC_W-1:0] t;
    for (int k = 0; k < 4; k++) t[k] = PC_W'($urandom);
    return t;
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    logic [3:0][PC_W-1:0] t;
    void'($urandom(32'h5eed));
    for (int l = 0; l < NLINES; l++)
      for (int w = 0; w < 4; w++) mem[l][w] = $urandom;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1");
    // fill banks
    for (int l = 0; l < NLINES; l++) begin
      wrEn = 1'b1; wrLine = 4'(l);
      for (int w = 0; w < 4; w++) wrData[w] = mem[l][w];
      @(posedge clk);
      @(negedge clk);
    end
    wrEn = 1'b0;
    t = rndTgt();
    fetch(16'h0020, 1, 1, 4'b0000, t, 1, 0, "R2");
    fetch(16'h0030, 1, 1, 4'b0000, t, 1, 0, "R2");
    fetch(16'h003C, 1, 1, 4'b0000, t, 1, 0, "R3");
    fetch(16'h0028, 1, 1, 4'b0000, t, 1, 0, "R3");
    fetch(16'h00F8, 1, 1, 4'b0000, t, 1, 0, "R3");
    fetch(16'h00EC, 1, 1, 4'b0000, t, 1, 0, "R3");
    fetch(16'h0014, 0, 1, 4'b0000, t, 1, 0, "R5");
    fetch(16'h0024, 1, 0, 4'b0000, t, 1, 0, "R4");
    fetch(16'h0018, 1, 0, 4'b0000, t, 1, 0, "R4");
    fetch(16'h0028, 0, 1, 4'b0000, t, 1, 0, "R6");
    fetch(16'h0034, 1, 0, 4'b1111, t, 1, 0, "R6");
    fetch(16'h0040, 1, 1, 4'b0010, t, 1, 0, "R7");
    fetch(16'h0044, 1, 1, 4'b1010, t, 1, 0, "R7");
    fetch(16'h004C, 1, 0, 4'b0100, t, 1, 0, "R7");
    fetch(16'h0058, 1, 1, 4'b0000, t, 1, 0, "R8");
    fetch(16'h0064, 1, 1, 4'b0001, t, 1, 0, "R7");
    fetch(16'h0070, 1, 1, 4'b0000, t, 1, 0, "R9");
    fetch(16'h00A4, 0, 0, 4'b0001, rndTgt(), 1, 1, "R9");
    fetch(16'h00B8, 1, 1, 4'b1000, rndTgt(), 0, 0, "R9");
    fetch(16'h00C8, 1, 1, 4'b0000, rndTgt(), 1, 1, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] h;
      logic en, st;
      h = 4'($urandom) & 4'($urandom);
      en = ($urandom % 8) != 0;
      st = ($urandom % 8) == 0;
      fetch(PC_W'($urandom), ($urandom % 5) != 0, ($urandom % 5) != 0, h, rndTgt(),
            en, st, (en && !st) ? "R3" : "R9");
    end
    finishRun();
  end
endmodule